// File: doc/BRIEF.md
# Precision Time Counter with Shadowed Commands

This block keeps a free-running 96-bit time value for packet timestamping. The value is made of three 32-bit words: a high word, a low word of whole nanoseconds, and a fraction word below the nanosecond. On every clock the block adds a 40-bit increment to the combined low and fraction words. Any carry into the high word lands in the same cycle. A second counter, the port timer, holds a copy of the lower 64 bits (low word plus fraction). It is updated from the same staged values, so the two counters never drift apart.

Software never writes the counters directly. It first writes shadow registers and then a command code. Nothing happens until the separate `sync_exec` strobe is raised. On the clock edge that samples the strobe, both counters act on the staged command together. The commands are:

- load a new time;
- load a new increment;
- step the time by a signed nanosecond offset;
- take a 96-bit snapshot into capture registers;
- arm an offset step that fires once the time reaches a programmed target.

Top module: `ptp_shadow_clock`

## Requirements
- R1: While reset is asserted and after it is released, both timers, the increment, the shadows, the command register and the capture registers are zero. With a zero increment, the time stays at zero.
- R2: On each clock that applies no command, the increment is added to the source value. The increment is the 40-bit value {inc_hi[7:0], inc_lo[31:0]}, aligned to the fraction word. The carry from fraction to low word and from low word to high word takes effect in that same cycle.
- R3: Register map for writes and reads:
  - address 0: shadow time, nanosecond word;
  - address 1: shadow time, high word;
  - address 2: shadow adjust, low word;
  - address 3: shadow adjust, high word;
  - address 4: command register (bits [2:0], reads back zero-extended);
  - addresses 5, 6, 7: read-only snapshot of the fraction, low and high words.
  Writing shadows or the command register alone never changes either timer.
- R4: Command code 1 (set time) loads the source value with {addr1, addr0, 32'h0} on the clock edge that samples `sync_exec` high. On that same edge the port timer is loaded with {addr0, 32'h0}.
- R5: Command code 2 (set increment) loads {addr3[7:0], addr2} as the new increment on the sync edge. The addition on that edge still uses the old increment.
- R6: Command code 3 (step) treats addr3 as a signed two's-complement nanosecond count. On the sync edge that count is added to the nanosecond part of both timers, together with the normal increment. Negative values move the time backward.
- R7: Command code 4 (snapshot) copies the source value as it stood just before the sync edge into the capture registers. The capture stays stable while the timer keeps running.
- R8: Command code 5 (step at time) arms a pending step. The target is {addr1, addr0} and the offset is addr3, both captured at the sync edge; `step_armed` goes high. On the first later edge where the source nanosecond value (bits [95:32]) is at or above the target and no other command is applied, the offset is added as in R6 and `step_armed` drops. Any other command applied by a sync takes precedence, and the pending step waits.
- R9: The port timer always equals bits [63:0] of the source timer.
- R10: Every sync edge clears the command register to 0. A sync with code 0, 6 or 7 leaves both timers advancing by the increment only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| sync_exec | input | 1 | Applies the staged command on this clock edge |
| src_time | output | 96 | Source timer {high, ns, fraction} |
| port_time | output | 64 | Port timer {ns, fraction} |
| step_armed | output | 1 | A step-at-time is pending |

## Verification
A wrong increment or carry shows on `src_time` at the very next sampled cycle, and the error keeps growing, so the per-clock comparison with a behavioural model catches it at once. A command that is decoded wrongly, or fires without a sync, shows as a jump in both timers on the sync edge itself. A pending step that never clears, or fires early, shows on `step_armed` and as an offset jump in the wrong cycle. A port timer that drifts from the source differs in its lower 64 bits from the first affected edge. A wrong snapshot is seen only when the capture addresses are read back.

// File: rtl/ptp_clk_pkg.sv
package ptp_clk_pkg;
  parameter int WORD_W   = 32;
  parameter int INC_HI_W = 8;
  parameter int INC_W    = WORD_W + INC_HI_W;
  parameter int ADDR_W   = 3;
  parameter int CMD_W    = 3;
  parameter int SH_N     = 4;

  localparam logic [ADDR_W-1:0] A_TIME_NS = 3'd0;
  localparam logic [ADDR_W-1:0] A_TIME_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_ADJ_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_ADJ_HI  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMD     = 3'd4;
  localparam logic [ADDR_W-1:0] A_CAP_FR  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CAP_NS  = 3'd6;
  localparam logic [ADDR_W-1:0] A_CAP_HI  = 3'd7;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE     = 3'd0,
    CMD_SET_TIME = 3'd1,
    CMD_SET_INC  = 3'd2,
    CMD_STEP     = 3'd3,
    CMD_SNAP     = 3'd4,
    CMD_STEP_AT  = 3'd5
  } tcmd_e;
endpackage

// File: rtl/ptp_cmd_ctrl.sv
module ptp_cmd_ctrl
  import ptp_clk_pkg::*;
#(
  parameter int NS_W = 2 * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic                 sync_exec,
  input  logic [NS_W-1:0]      src_ns,
  output logic [WORD_W-1:0]    sh_ns,
  output logic [WORD_W-1:0]    sh_hi,
  output logic [WORD_W-1:0]    sh_adj_lo,
  output logic [WORD_W-1:0]    sh_adj_hi,
  output logic [CMD_W-1:0]     cmd_out,
  output logic                 ld_time,
  output logic                 ld_inc,
  output logic                 do_adj,
  output logic [WORD_W-1:0]    adj_delta,
  output logic                 cap_en,
  output logic                 armed
);
  logic [WORD_W-1:0] sh_q [SH_N];
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic              armed_q, armed_d;
  logic [NS_W-1:0]   tgt_q, tgt_d;
  logic [WORD_W-1:0] dlt_q, dlt_d;
  tcmd_e             act;
  logic              arm, fire;

  for (genvar g = 0; g < SH_N; g++) begin : g_shadow
    logic sh_en;
    assign sh_en = wr_en && (wr_addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sh_q[g] <= '0;
      else if (sh_en)  sh_q[g] <= wr_data;
    end
  end

  assign sh_ns     = sh_q[0];
  assign sh_hi     = sh_q[1];
  assign sh_adj_lo = sh_q[2];
  assign sh_adj_hi = sh_q[3];

  always_comb begin
    act = CMD_NONE;
    if (sync_exec) begin
      case (cmd_q)
        CMD_SET_TIME: act = CMD_SET_TIME;
        CMD_SET_INC:  act = CMD_SET_INC;
        CMD_STEP:     act = CMD_STEP;
        CMD_SNAP:     act = CMD_SNAP;
        CMD_STEP_AT:  act = CMD_STEP_AT;
        default:      act = CMD_NONE;
      endcase
    end
  end

  always_comb begin
    ld_time   = (act == CMD_SET_TIME);
    ld_inc    = (act == CMD_SET_INC);
    cap_en    = (act == CMD_SNAP);
    arm       = (act == CMD_STEP_AT);
    fire      = armed_q && (act == CMD_NONE) && (src_ns >= tgt_q);
    do_adj    = (act == CMD_STEP) || fire;
    adj_delta = (act == CMD_STEP) ? sh_q[3] : dlt_q;
  end

  always_comb begin
    cmd_d   = cmd_q;
    armed_d = armed_q;
    tgt_d   = tgt_q;
    dlt_d   = dlt_q;
    if (sync_exec)                        cmd_d = CMD_NONE;
    else if (wr_en && wr_addr == A_CMD)   cmd_d = wr_data[CMD_W-1:0];
    if (arm) begin
      armed_d = 1'b1;
      tgt_d   = NS_W'({sh_q[1], sh_q[0]});
      dlt_d   = sh_q[3];
    end else if (fire) begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      armed_q <= 1'b0;
      tgt_q   <= '0;
      dlt_q   <= '0;
    end else begin
      cmd_q   <= cmd_d;
      armed_q <= armed_d;
      tgt_q   <= tgt_d;
      dlt_q   <= dlt_d;
    end
  end

  assign cmd_out = cmd_q;
  assign armed   = armed_q;

  // R10
  cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_exec |=> (cmd_q == '0));

  // R8
  single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_time, ld_inc, do_adj, cap_en, arm}));

  // R8
  arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_exec && cmd_q == CMD_STEP_AT) |=> armed_q);
endmodule

// File: rtl/ptp_time_acc.sv
module ptp_time_acc
  import ptp_clk_pkg::*;
#(
  parameter int NS_W = 2 * WORD_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_time,
  input  logic [NS_W-1:0]         ns_init,
  input  logic                    ld_inc,
  input  logic [INC_W-1:0]        inc_in,
  input  logic                    do_adj,
  input  logic [WORD_W-1:0]       adj,
  output logic [NS_W+WORD_W-1:0]  value
);
  localparam int TOT_W = NS_W + WORD_W;

  logic [TOT_W-1:0] val_q, val_d, sum, adj_full;
  logic [INC_W-1:0] inc_q, inc_d;

  if (NS_W > WORD_W) begin : g_sext
    assign adj_full = {{(NS_W-WORD_W){adj[WORD_W-1]}}, adj, {WORD_W{1'b0}}};
  end else begin : g_plain
    assign adj_full = {adj, {WORD_W{1'b0}}};
  end

  assign sum = val_q + {{(TOT_W-INC_W){1'b0}}, inc_q};

  always_comb begin
    inc_d = inc_q;
    if (ld_inc) inc_d = inc_in;
    if (ld_time)     val_d = {ns_init, {WORD_W{1'b0}}};
    else if (do_adj) val_d = sum + adj_full;
    else             val_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      inc_q <= '0;
    end else begin
      val_q <= val_d;
      inc_q <= inc_d;
    end
  end

  assign value = val_q;

  // R4
  load_frac_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_time |=> (val_q[WORD_W-1:0] == '0));

  // R5
  inc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_inc |=> $stable(inc_q));
endmodule

// File: rtl/ptp_shadow_clock.sv
module ptp_shadow_clock
  import ptp_clk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        sync_exec,
  output logic [95:0] src_time,
  output logic [63:0] port_time,
  output logic        step_armed
);
  localparam int SRC_NS_W  = 2 * WORD_W;
  localparam int PORT_NS_W = WORD_W;
  localparam int SRC_W     = SRC_NS_W + WORD_W;

  logic [WORD_W-1:0] sh_ns, sh_hi, sh_adj_lo, sh_adj_hi, adj_delta;
  logic [CMD_W-1:0]  cmd_q;
  logic              ld_time, ld_inc, do_adj, cap_en;
  logic [SRC_W-1:0]  src_val, cap_q;
  logic [INC_W-1:0]  new_inc;

  assign new_inc = {sh_adj_hi[INC_HI_W-1:0], sh_adj_lo};

  ptp_cmd_ctrl #(.NS_W(SRC_NS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_exec(sync_exec),
    .src_ns(src_val[SRC_W-1:WORD_W]),
    .sh_ns(sh_ns), .sh_hi(sh_hi), .sh_adj_lo(sh_adj_lo), .sh_adj_hi(sh_adj_hi),
    .cmd_out(cmd_q), .ld_time(ld_time), .ld_inc(ld_inc), .do_adj(do_adj),
    .adj_delta(adj_delta), .cap_en(cap_en), .armed(step_armed)
  );

  ptp_time_acc #(.NS_W(SRC_NS_W)) u_src (
    .clk(clk), .rst_n(rst_n), .ld_time(ld_time), .ns_init({sh_hi, sh_ns}),
    .ld_inc(ld_inc), .inc_in(new_inc), .do_adj(do_adj), .adj(adj_delta),
    .value(src_val)
  );

  ptp_time_acc #(.NS_W(PORT_NS_W)) u_port (
    .clk(clk), .rst_n(rst_n), .ld_time(ld_time), .ns_init(sh_ns),
    .ld_inc(ld_inc), .inc_in(new_inc), .do_adj(do_adj), .adj(adj_delta),
    .value(port_time)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= src_val;
  end

  always_comb begin
    case (rd_addr)
      A_TIME_NS: rd_data = sh_ns;
      A_TIME_HI: rd_data = sh_hi;
      A_ADJ_LO:  rd_data = sh_adj_lo;
      A_ADJ_HI:  rd_data = sh_adj_hi;
      A_CMD:     rd_data = {{(WORD_W-CMD_W){1'b0}}, cmd_q};
      A_CAP_FR:  rd_data = cap_q[WORD_W-1:0];
      A_CAP_NS:  rd_data = cap_q[2*WORD_W-1:WORD_W];
      default:   rd_data = cap_q[3*WORD_W-1:2*WORD_W];
    endcase
  end

  assign src_time = src_val;

  // R9
  port_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_time == src_val[2*WORD_W-1:0]);

  // R7
  snap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (cap_q == $past(src_val)));

  // R3
  quiet_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_exec && !step_armed) |=> (src_val[WORD_W-1:0] == $past(src_val[WORD_W-1:0]) + $past(u_src.inc_q[WORD_W-1:0])));
endmodule

// File: tb/ptp_shadow_clock_tb.sv
`timescale 1ns/100ps
module ptp_shadow_clock_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic        sync_exec = 1'b0;
  logic [31:0] rd_data;
  logic [95:0] src_time;
  logic [63:0] port_time;
  logic        step_armed;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ptp_shadow_clock u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sync_exec(sync_exec), .src_time(src_time), .port_time(port_time),
    .step_armed(step_armed)
  );

  // behavioural reference
  logic [95:0] m_src, m_cap;
  logic [63:0] m_port, m_tgt;
  logic [39:0] m_inc;
  logic [31:0] m_sh [4];
  logic [31:0] m_dlt;
  logic [2:0]  m_cmd;
  logic        m_armed;

  always @(posedge clk) begin
    logic [95:0] ns;
    logic [63:0] np;
    logic [39:0] ni;
    logic [31:0] d;
    int act;
    logic fire;
    if (!rst_n) begin
      m_src = '0; m_cap = '0; m_port = '0; m_tgt = '0; m_inc = '0;
      m_dlt = '0; m_cmd = '0; m_armed = 1'b0;
      for (int i = 0; i < 4; i++) m_sh[i] = '0;
    end else begin
      ns = m_src + 96'(m_inc);
      np = m_port + 64'(m_inc);
      ni = m_inc;
      act = sync_exec ? int'(m_cmd) : 0;
      if (act > 5) act = 0;
      fire = (act == 0) && m_armed && (m_src[95:32] >= m_tgt);
      if (act == 1) begin ns = {m_sh[1], m_sh[0], 32'h0}; np = {m_sh[0], 32'h0}; end
      if (act == 2) ni = {m_sh[3][7:0], m_sh[2]};
      if (act == 3 || fire) begin
        d = (act == 3) ? m_sh[3] : m_dlt;
        ns = ns + {{32{d[31]}}, d, 32'h0};
        np = np + {d, 32'h0};
      end
      if (act == 4) m_cap = m_src;
      if (act == 5) begin m_armed = 1'b1; m_tgt = {m_sh[1], m_sh[0]}; m_dlt = m_sh[3]; end
      else if (fire) m_armed = 1'b0;
      if (sync_exec) m_cmd = '0;
      else if (wr_en && wr_addr == 3'd4) m_cmd = wr_data[2:0];
      if (wr_en && wr_addr < 3'd4) m_sh[wr_addr[1:0]] = wr_data;
      m_src = ns; m_port = np; m_inc = ni;
    end
  end

  function automatic logic [31:0] m_rd(input logic [2:0] a);
    case (a)
      3'd0, 3'd1, 3'd2, 3'd3: return m_sh[a[1:0]];
      3'd4: return {29'h0, m_cmd};
      3'd5: return m_cap[31:0];
      3'd6: return m_cap[63:32];
      default: return m_cap[95:64];
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (src_time !== m_src) begin
        errors++;
        $display("FAIL R2 R4 R5 R6 R8 R10 src_time act=%h exp=%h", src_time, m_src);
      end
      checks++;
      if (port_time !== m_port) begin
        errors++;
        $display("FAIL R9 port_time act=%h exp=%h", port_time, m_port);
      end
      checks++;
      if (step_armed !== m_armed) begin
        errors++;
        $display("FAIL R8 step_armed act=%b exp=%b", step_armed, m_armed);
      end
      checks++;
      if (rd_data !== m_rd(rd_addr)) begin
        errors++;
        $display("FAIL R3 R7 rd_data[%0d] act=%h exp=%h", rd_addr, rd_data, m_rd(rd_addr));
      end
    end
  end

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [2:0] a, input logic [31:0] d, input logic s);
    @(negedge clk); #1;
    wr_en = we; wr_addr = a; wr_data = d; sync_exec = s;
    @(negedge clk); #1;
    wr_en = 1'b0; sync_exec = 1'b0;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    drive(1'b1, a, d, 1'b0);
  endtask

  task automatic do_sync();
    drive(1'b0, 3'd0, 32'h0, 1'b1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [95:0] t0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    chk("R1 reset time", src_time, 96'h0);
    chk("R1 reset port", {32'h0, port_time}, 96'h0);

    // R5 increment of 1.5 ns
    wreg(3'd2, 32'h8000_0000);
    wreg(3'd3, 32'h0000_0001);
    wreg(3'd4, 32'd2);
    rd_addr = 3'd4;
    idle(2);
    chk("R3 cmd readback", {64'h0, rd_data}, 96'd2);
    chk("R5 no change before sync", src_time, 96'h0);
    do_sync();
    chk("R10 cmd cleared", {64'h0, rd_data}, 96'd0);
    idle(10);

    // R3 shadow writes alone leave time on its course
    wreg(3'd0, 32'hFFFF_FFF0);
    wreg(3'd1, 32'h0000_0005);
    wreg(3'd4, 32'd1);
    idle(3);
    do_sync();
    chk("R4 set time", src_time, {32'h5, 32'hFFFF_FFF0, 32'h0});
    idle(20);
    chk("R2 carry into high", src_time, {32'h6, 32'h0000_000E, 32'h0});

    // R6 negative step
    wreg(3'd3, 32'hFFFF_FFEC);
    wreg(3'd4, 32'd3);
    t0 = src_time;
    do_sync();
    chk("R6 step back", src_time, t0 + 2 * 96'h1_8000_0000 + {32'hFFFF_FFFF, 32'hFFFF_FFEC, 32'h0});
    wreg(3'd3, 32'd1000);
    wreg(3'd4, 32'd3);
    idle(5);

    // R7 snapshot
    wreg(3'd4, 32'd4);
    @(negedge clk); #1;
    t0 = src_time;
    sync_exec = 1'b1;
    @(negedge clk); #1;
    sync_exec = 1'b0;
    idle(7);
    rd_addr = 3'd5; #1; chk("R7 cap fraction", {64'h0, rd_data}, {64'h0, t0[31:0]});
    rd_addr = 3'd6; #1; chk("R7 cap ns", {64'h0, rd_data}, {64'h0, t0[63:32]});
    rd_addr = 3'd7; #1; chk("R7 cap high", {64'h0, rd_data}, {64'h0, t0[95:64]});

    // R10 sync with no or unused code
    do_sync();
    wreg(3'd4, 32'd7);
    do_sync();
    rd_addr = 3'd4; #1;
    chk("R10 unused code clears", {64'h0, rd_data}, 96'h0);

    // R8 step at time
    t0 = src_time;
    wreg(3'd0, t0[63:32] + 32'd60);
    wreg(3'd1, t0[95:64]);
    wreg(3'd3, 32'd500);
    wreg(3'd4, 32'd5);
    do_sync();
    chk("R8 armed", {95'h0, step_armed}, 96'h1);
    idle(60);
    chk("R8 fired", {95'h0, step_armed}, 96'h0);

    // R8 pending step deferred by other command
    wreg(3'd0, 32'hFFFF_FFFF);
    wreg(3'd1, 32'hFFFF_FFFF);
    wreg(3'd4, 32'd5);
    do_sync();
    wreg(3'd0, 32'h0000_1000);
    wreg(3'd1, 32'h0);
    wreg(3'd4, 32'd1);
    do_sync();
    idle(4);

    // R2 large increment with heavy carries
    wreg(3'd2, 32'hFFFF_FFFF);
    wreg(3'd3, 32'h0000_00FF);
    wreg(3'd4, 32'd2);
    do_sync();
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      idle(3);
    end
    idle(20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule